// File: doc/BRIEF.md
# Acquisition Trigger Scheduler

This block decides when a sensing acquisition cycle begins and when the sensing front end may sleep. It issues a single-cycle start pulse to an acquisition engine. It then treats the cycle as active until the engine answers with a done pulse. A sleep indicator is raised whenever no cycle is active and no start is waiting.

There are three trigger behaviours. In edge mode, a cycle begins only after a rising edge on an asynchronous sync input. In timed mode, cycles begin at a fixed interval of the repeat field times one time unit. A repeat value of zero in timed mode gives back-to-back free running. The time unit nominally stands for 16 ms. It is produced by an internal prescaler whose length in clocks is a parameter, so a short unit can be used in simulation.

The trigger-select and repeat inputs are expected to be static while the block is out of reset. The recommended power-up configuration is timed mode with a repeat of 2.

Top module: `acq_trigger_sched`

## Requirements
- R1: In edge mode (edge_mode_i = 1), starts follow only rising edges of sync_i. If sync_i is first sampled high at clock edge k, start_o is high in the cycle that follows edge k+1.
- R2: In edge mode, once done_i ends a cycle, sleep_o stays high and no start is issued until sync_i falls and rises again; a sync_i level held high does not retrigger.
- R3: In edge mode, a rising edge of sync_i during an active cycle is held. start_o is then high in the cycle right after the done_i pulse. Any number of rising edges within one active cycle yield one start only.
- R4: In timed mode (edge_mode_i = 0) with repeat_i = N > 0, consecutive starts are exactly N*UNIT_CYCLES clocks apart when each cycle completes in time. The first start occurs in the first cycle after reset is released.
- R5: In timed mode, if a cycle is still active when its period has elapsed, the next start is issued in the cycle right after done_i.
- R6: In timed mode with repeat_i = 0, the next start is issued in the cycle right after done_i, and sleep_o never goes high.
- R7: start_o is high for exactly one clock per start, and is never high while a cycle is active (from the cycle after a start until done_i is accepted).
- R8: sleep_o is high exactly when no cycle is active and no start is due. It is high during reset in edge mode, and between done_i and the next timed start.
- R9: A done_i pulse while no cycle is active is ignored: sleep_o stays high, no start results, and the next sync rising edge still starts a cycle with normal latency.
- R10: With the recommended configuration (timed, repeat_i = 2), starts are 2*UNIT_CYCLES clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Asynchronous external sync; rising edges trigger in edge mode |
| edge_mode_i | input | 1 | Trigger select: 1 = edge, 0 = timed |
| repeat_i | input | RPT_W | Repeat interval in time units; 0 = free running |
| done_i | input | 1 | One-cycle pulse from the acquisition engine when a cycle finishes |
| start_o | output | 1 | One-cycle pulse that begins an acquisition cycle |
| sleep_o | output | 1 | High while idle with nothing pending |

## Verification
The assertions take three things for granted. The trigger-select and repeat inputs are held constant from reset release onward. done_i is pulsed only while a cycle is active, and never in the same cycle as start_o. Each level of sync_i lasts at least three clocks. The bench keeps to these rules as follows. Every scenario applies its configuration while reset is asserted. done_i is driven only after an observed start. The sync input is toggled with high and low phases of three or more clocks. The one deliberate done_i while idle is issued in edge mode, and the checker's interval and pending properties do not cover that case.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;
  typedef enum logic {
    TRIG_TIMED = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/acq_sync_rise.sv
module acq_sync_rise #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/acq_period_timer.sv
module acq_period_timer #(
  parameter int unsigned UNIT_CYCLES = 800000,
  parameter int unsigned RPT_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [RPT_W-1:0] repeat_i,
  output logic             due_o
);
  localparam int unsigned PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [RPT_W-1:0] unit_q;
  logic             due_q;
  logic             tick;
  logic [RPT_W:0]   unit_nxt;
  logic             reached;

  assign tick     = (pre_q == PRE_LAST) & ~due_q;
  assign unit_nxt = {1'b0, unit_q} + 1'b1;
  assign reached  = unit_nxt >= {1'b0, repeat_i};
  // due in the tick cycle itself so the interval is exactly N units
  assign due_o    = due_q | (tick & reached);

  // due_q resets high: first timed start right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      unit_q <= '0;
      due_q  <= 1'b1;
    end else if (restart_i) begin
      pre_q  <= '0;
      unit_q <= '0;
      due_q  <= 1'b0;
    end else if (!due_q) begin
      if (tick) begin
        pre_q  <= '0;
        unit_q <= unit_nxt[RPT_W-1:0];
        due_q  <= reached;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acq_trigger_sched.sv
module acq_trigger_sched
  import acq_trig_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES = 800000,
  parameter int unsigned RPT_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             edge_mode_i,
  input  logic [RPT_W-1:0] repeat_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             sleep_o
);
  trig_mode_e mode;
  logic       rise;
  logic       due;
  logic       busy_q;
  logic       pend_q;
  logic       want;
  logic       start;

  assign mode = trig_mode_e'(edge_mode_i);

  acq_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sync_i),
    .rise_o (rise)
  );

  acq_period_timer #(.UNIT_CYCLES(UNIT_CYCLES), .RPT_W(RPT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start),
    .repeat_i (repeat_i),
    .due_o    (due)
  );

  always_comb begin
    unique case (mode)
      TRIG_EDGE:  want = pend_q | rise;
      default:    want = (repeat_i == '0) ? 1'b1 : due;
    endcase
  end

  assign start = ~busy_q & want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start)   busy_q <= 1'b1;
    else if (done_i)  busy_q <= 1'b0;
  end

  // one pending slot: edges during a cycle collapse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (mode != TRIG_EDGE)  pend_q <= 1'b0;
    else                         pend_q <= (pend_q | rise) & ~start;
  end

  assign start_o = start;
  assign sleep_o = ~busy_q & ~want;
endmodule

// File: rtl/acq_trigger_sched_chk.sv
module acq_trigger_sched_chk #(
  parameter int unsigned UNIT_CYCLES = 800000,
  parameter int unsigned RPT_W       = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             edge_mode_i,
  input logic [RPT_W-1:0] repeat_i,
  input logic             done_i,
  input logic             start_o,
  input logic             sleep_o
);
  logic        active_q;
  logic        seen_q;
  logic        sync_prev_q;
  logic        rise_flag_q;
  logic [31:0] gap_q;
  logic [32:0] rep_cycles;

  assign rep_cycles = 33'(UNIT_CYCLES) * 33'(repeat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      seen_q      <= 1'b0;
      sync_prev_q <= 1'b0;
      rise_flag_q <= 1'b0;
      gap_q       <= '0;
    end else begin
      sync_prev_q <= sync_i;
      if (start_o)     active_q <= 1'b1;
      else if (done_i) active_q <= 1'b0;
      if (start_o)     seen_q <= 1'b1;
      if (sync_i && !sync_prev_q) rise_flag_q <= 1'b1;
      else if (start_o)           rise_flag_q <= 1'b0;
      if (start_o)                gap_q <= 32'd1;
      else if (gap_q != '1)       gap_q <= gap_q + 32'd1;
    end
  end

  p_start_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_no_start_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> !start_o);

  p_sleep_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> (!active_q && !start_o));

  p_edge_needs_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && start_o) |-> rise_flag_q);

  p_timed_interval_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && repeat_i != '0 && start_o && seen_q) |-> ({1'b0, gap_q} >= rep_cycles));

  p_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && repeat_i != '0 && active_q && done_i && ({1'b0, gap_q} + 33'd1 >= rep_cycles))
    |=> start_o);

  p_free_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && repeat_i == '0 && active_q && done_i) |=> start_o);

  p_free_awake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && repeat_i == '0) |-> !sleep_o);
endmodule

bind acq_trigger_sched acq_trigger_sched_chk #(
  .UNIT_CYCLES(UNIT_CYCLES),
  .RPT_W      (RPT_W)
) u_chk (.*);

// File: tb/acq_trigger_sched_bench.sv
module acq_trigger_sched_bench;
  localparam int unsigned UNIT  = 8;
  localparam int unsigned RPT_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sync_i = 1'b0;
  logic             edge_mode_i = 1'b0;
  logic [RPT_W-1:0] repeat_i = '0;
  logic             done_i = 1'b0;
  logic             start_o;
  logic             sleep_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  acq_trigger_sched #(.UNIT_CYCLES(UNIT), .RPT_W(RPT_W)) u_acq_trigger_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .edge_mode_i(edge_mode_i),
    .repeat_i(repeat_i), .done_i(done_i), .start_o(start_o), .sleep_o(sleep_o)
  );

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic apply_reset(input bit edge_m, input int rep);
    @(negedge clk_i);
    rst_ni = 1'b0;
    edge_mode_i = edge_m;
    repeat_i = RPT_W'(rep);
    sync_i = 1'b0;
    done_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic pulse_done();
    @(negedge clk_i);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  task automatic wait_start(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (start_o) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic t_reset_state();
    apply_reset(1'b1, 2);
    rst_ni = 1'b0;
    #1;
    check(start_o == 1'b0, "R8 reset start", int'(start_o), 0);
    check(sleep_o == 1'b1, "R8 reset sleep", int'(sleep_o), 1);
    rst_ni = 1'b1;
  endtask

  task automatic t_edge_basic();
    int c;
    int bad;
    apply_reset(1'b1, 2);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (start_o || !sleep_o) bad++;
    end
    check(bad == 0, "R1 no start without edge", bad, 0);
    @(negedge clk_i);
    sync_i = 1'b1;
    c = cyc;
    @(negedge clk_i);
    check(start_o == 1'b0, "R1 latency early", int'(start_o), 0);
    @(negedge clk_i);
    check(start_o == 1'b1 && cyc == c + 2, "R1 start after edge", cyc - c, 2);
    @(negedge clk_i);
    check(start_o == 1'b0, "R7 single pulse", int'(start_o), 0);
    check(sleep_o == 1'b0, "R8 awake while active", int'(sleep_o), 0);
    repeat (3) @(negedge clk_i);
    pulse_done();
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (start_o || !sleep_o) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R2 sleeps with sync held high", bad, 0);
    sync_i = 1'b0;
    repeat (4) @(negedge clk_i);
    sync_i = 1'b1;
    c = cyc;
    repeat (2) @(negedge clk_i);
    check(start_o == 1'b1 && cyc == c + 2, "R2 new edge restarts", int'(start_o), 1);
    pulse_done();
  endtask

  task automatic t_edge_pending();
    int at;
    int bad;
    apply_reset(1'b1, 2);
    @(negedge clk_i);
    sync_i = 1'b1;
    wait_start(at);
    check(at >= 0, "R3 initial start", at, 0);
    repeat (3) @(negedge clk_i); sync_i = 1'b0;
    repeat (3) @(negedge clk_i); sync_i = 1'b1;
    repeat (3) @(negedge clk_i); sync_i = 1'b0;
    repeat (3) @(negedge clk_i); sync_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check(start_o == 1'b0, "R7 no start while active", int'(start_o), 0);
    pulse_done();
    check(start_o == 1'b1, "R3 pending start after done", int'(start_o), 1);
    @(negedge clk_i);
    check(start_o == 1'b0, "R7 pending pulse width", int'(start_o), 0);
    repeat (2) @(negedge clk_i);
    pulse_done();
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      if (start_o || !sleep_o) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R3 edges collapse to one start", bad, 0);
  endtask

  task automatic t_done_idle();
    int bad;
    int c;
    apply_reset(1'b1, 2);
    repeat (2) @(negedge clk_i);
    pulse_done();
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      if (start_o || !sleep_o) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R9 idle done ignored", bad, 0);
    sync_i = 1'b1;
    c = cyc;
    repeat (2) @(negedge clk_i);
    check(start_o == 1'b1 && cyc == c + 2, "R9 edge still starts", int'(start_o), 1);
    pulse_done();
  endtask

  task automatic t_timed_default();
    int s;
    int at;
    apply_reset(1'b0, 2);
    #1;
    check(start_o == 1'b1, "R4 first start after reset", int'(start_o), 1);
    s = cyc;
    repeat (2) @(negedge clk_i);
    pulse_done();
    check(sleep_o == 1'b1, "R8 sleep between timed starts", int'(sleep_o), 1);
    wait_start(at);
    check(at - s == 2 * UNIT, "R10 default period", at - s, 2 * UNIT);
    pulse_done();
  endtask

  task automatic t_timed_rep3();
    int s;
    int at;
    apply_reset(1'b0, 3);
    #1;
    s = cyc;
    repeat (4) @(negedge clk_i);
    pulse_done();
    wait_start(at);
    check(at - s == 3 * UNIT, "R4 period first", at - s, 3 * UNIT);
    s = at;
    repeat (10) @(negedge clk_i);
    pulse_done();
    wait_start(at);
    check(at - s == 3 * UNIT, "R4 period second", at - s, 3 * UNIT);
    pulse_done();
  endtask

  task automatic t_overrun();
    int bad;
    apply_reset(1'b0, 1);
    #1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (start_o) bad++;
    end
    check(bad == 0, "R7 no start during long cycle", bad, 0);
    pulse_done();
    check(start_o == 1'b1, "R5 start right after late done", int'(start_o), 1);
    pulse_done();
  endtask

  task automatic t_free_run();
    int bad;
    apply_reset(1'b0, 0);
    #1;
    check(start_o == 1'b1, "R6 first free start", int'(start_o), 1);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      repeat (2) begin
        @(negedge clk_i);
        if (sleep_o) bad++;
      end
      pulse_done();
      check(start_o == 1'b1, "R6 back-to-back start", int'(start_o), 1);
      if (sleep_o) bad++;
    end
    check(bad == 0, "R6 never sleeps", bad, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_edge_basic();
    t_edge_pending();
    t_done_idle();
    t_timed_default();
    t_timed_rep3();
    t_overrun();
    t_free_run();
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule